// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is a slave on a two-wire serial bus. It gives an external bus master read and write access to a register space with 16-bit addresses. SCL and SDA are oversampled on the system clock through two-flop synchronisers. The block recognises start, repeated-start and stop conditions and compares the incoming 7-bit device address with its own. It pulls SDA low through an open-drain enable to acknowledge bytes and to send read data.

An internal 16-bit pointer chooses the register being accessed. In a write transaction, the first two bytes after the address byte load this pointer, most significant byte first. Every byte after those is written at the pointer, and the pointer then increments. A read transaction returns bytes starting at the current pointer, and the pointer advances after each byte. The pointer keeps its value across stop conditions. This allows three access patterns: a pointer-only write, a read with no pointer bytes, and a pointer write followed by a repeated start and a read.

Toward the register file the block has a synchronous strobe interface: an address, write data, a one-cycle write strobe, a one-cycle read strobe, and a read-data return.

Top module: `i2c_reg_slave`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sda_oe`, `reg_we` and `reg_re` are low.
- R2: The first byte after a start is a 7-bit device address, MSB first, followed by a direction bit (0 = master writes, 1 = master reads). On a match the slave pulls SDA low on the ninth clock. On a mismatch it never drives SDA and issues no strobes until the next start.
- R3: In a write transaction, the two bytes after the address byte load the 16-bit pointer, high byte first. The slave acknowledges each of them.
- R4: Each later byte in a write transaction is acknowledged and produces exactly one `reg_we` pulse of one cycle, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The pointer then increments by one.
- R5: A write that carries only the two pointer bytes and then a stop writes no register. A following read returns data from the loaded pointer.
- R6: A read transaction that begins straight after the address byte shifts out bytes MSB first, starting at the current pointer. The pointer increments after each byte. The pointer keeps its value across stop conditions.
- R7: Pointer bytes followed by a repeated start and a read address byte return data starting at the newly loaded pointer.
- R8: The pointer wraps from 0xFFFF to 0x0000.
- R9: A not-acknowledge from the master after a read byte ends the transfer. The slave releases SDA and ignores further clocks until a start.
- R10: A start or stop at any bit position aborts the current byte. A partly received byte is never written.
- R11: `sda_oe` changes only while the synchronised SCL is low.
- R12: `reg_re` is a one-cycle pulse carrying `reg_addr`. The block samples `reg_rdata` in the cycle after that pulse, and takes it at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| reg_addr | output | 16 | Register address for the current strobe |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data, valid in the cycle after `reg_re` |

## Verification
Each bus edge reaches the control logic three system clocks after the pin changes: two synchroniser flops and one edge-detect register. An acknowledge or a data bit therefore appears on SDA a few clocks after an SCL fall. The bench holds every SCL phase for sixteen clocks and samples SDA in the middle of the high phase, so each driven value is stable well before it is sampled. Write strobes come one clock after the synchronised SCL fall that ends the eighth bit; a scoreboard monitor compares them on falling clock edges against the queued expected address and data. The bench register model presents read data only in the single cycle after `reg_re`, so a capture one cycle early or late reads zero and shows up as a wrong read byte.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

    localparam int BYTE_W = 8;
    localparam int PTR_W  = 16;
    localparam int DEVA_W = 7;
    localparam int CNT_W  = $clog2(BYTE_W + 2);

    // bit counter milestones inside one nine-clock byte slot
    localparam logic [CNT_W-1:0] CNT_BYTE_DONE = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_ACK_SEEN  = CNT_W'(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVADR,
        ST_PTRH,
        ST_PTRL,
        ST_WDATA,
        ST_RDATA
    } xfer_st_e;

    typedef struct packed {
        logic scl_lvl;
        logic sda_lvl;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic set_hi;
        logic set_lo;
        logic inc;
    } ptr_cmd_t;

    // state entered once the acknowledge slot of a received byte closes
    function automatic xfer_st_e after_ack(input xfer_st_e s, input logic rd);
        case (s)
            ST_DEVADR: after_ack = rd ? ST_RDATA : ST_PTRH;
            ST_PTRH:   after_ack = ST_PTRL;
            ST_PTRL:   after_ack = ST_WDATA;
            ST_WDATA:  after_ack = ST_WDATA;
            default:   after_ack = ST_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/i2cr_sync.sv
module i2cr_sync
    import i2cr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= scl_i;
                    sda_ff <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= {scl_ff[STAGES-2:0], scl_i};
                    sda_ff <= {sda_ff[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_ff[LAST];
    assign sda_s = sda_ff[LAST];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev.scl_lvl  = scl_s;
        ev.sda_lvl  = sda_s;
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/i2cr_ptr.sv
module i2cr_ptr
    import i2cr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ptr_cmd_t          cmd,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [PTR_W-1:0]  ptr_o
);
    logic [PTR_W-BYTE_W-1:0] hi_q;
    logic [PTR_W-1:0]        ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q  <= '0;
            ptr_q <= '0;
        end else begin
            if (cmd.set_hi) hi_q <= byte_i[PTR_W-BYTE_W-1:0];
            if (cmd.set_lo)   ptr_q <= {hi_q, byte_i};
            else if (cmd.inc) ptr_q <= ptr_q + 1'b1;
        end
    end

    assign ptr_o = ptr_q;

    // R8
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.inc && !cmd.set_lo && ptr_q == '1) |=> (ptr_q == '0));

endmodule

// File: rtl/i2cr_ctrl.sv
module i2cr_ctrl
    import i2cr_pkg::*;
#(
    parameter logic [DEVA_W-1:0] DEV_ADDR = 7'h2A
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [PTR_W-1:0]  ptr,
    output ptr_cmd_t          pcmd,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [BYTE_W-1:0] reg_rdata
);
    xfer_st_e          st_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              ack_ph_q;
    logic [BYTE_W-1:0] rx_q;
    logic [BYTE_W-1:0] tx_q;
    logic              oe_q;
    logic              we_q;
    logic              re_q;
    logic              re_d_q;
    logic [PTR_W-1:0]  addr_q;
    logic [BYTE_W-1:0] wdata_q;

    logic rx_done;
    logic adr_hit;
    logic wr_fire;
    logic mst_ack_slot;
    logic rx_state;

    always_comb begin
        rx_state     = (st_q == ST_DEVADR) || (st_q == ST_PTRH) ||
                       (st_q == ST_PTRL)   || (st_q == ST_WDATA);
        rx_done      = ev.scl_fall && !ack_ph_q && rx_state &&
                       (cnt_q == CNT_BYTE_DONE);
        adr_hit      = (rx_q[BYTE_W-1:1] == DEV_ADDR);
        wr_fire      = rx_done && (st_q == ST_WDATA);
        mst_ack_slot = ev.scl_rise && (st_q == ST_RDATA) &&
                       (cnt_q == CNT_BYTE_DONE);
        pcmd.set_hi  = rx_done && (st_q == ST_PTRH);
        pcmd.set_lo  = rx_done && (st_q == ST_PTRL);
        pcmd.inc     = wr_fire || mst_ack_slot;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            cnt_q    <= '0;
            ack_ph_q <= 1'b0;
            rx_q     <= '0;
            tx_q     <= '0;
            oe_q     <= 1'b0;
            we_q     <= 1'b0;
            re_q     <= 1'b0;
            re_d_q   <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
        end else begin
            we_q   <= 1'b0;
            re_q   <= 1'b0;
            re_d_q <= re_q;
            if (re_d_q) tx_q <= reg_rdata;

            if (ev.start) begin
                st_q     <= ST_DEVADR;
                cnt_q    <= '0;
                ack_ph_q <= 1'b0;
                oe_q     <= 1'b0;
            end else if (ev.stop) begin
                st_q     <= ST_IDLE;
                cnt_q    <= '0;
                ack_ph_q <= 1'b0;
                oe_q     <= 1'b0;
            end else if (st_q == ST_RDATA) begin
                if (ev.scl_rise && cnt_q < CNT_BYTE_DONE)
                    cnt_q <= cnt_q + 1'b1;
                if (mst_ack_slot) begin
                    if (ev.sda_lvl) begin
                        st_q <= ST_IDLE;
                    end else begin
                        re_q   <= 1'b1;
                        addr_q <= ptr + 1'b1;
                        cnt_q  <= CNT_ACK_SEEN;
                    end
                end
                if (ev.scl_fall) begin
                    if (cnt_q == CNT_BYTE_DONE) begin
                        oe_q <= 1'b0;
                    end else if (cnt_q == CNT_ACK_SEEN) begin
                        oe_q  <= ~tx_q[BYTE_W-1];
                        cnt_q <= '0;
                    end else if (cnt_q != '0) begin
                        tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                        oe_q <= ~tx_q[BYTE_W-2];
                    end
                end
            end else if (rx_state) begin
                if (ack_ph_q) begin
                    if (ev.scl_fall) begin
                        ack_ph_q <= 1'b0;
                        cnt_q    <= '0;
                        st_q     <= after_ack(st_q, rx_q[0]);
                        oe_q     <= (after_ack(st_q, rx_q[0]) == ST_RDATA) ?
                                    ~tx_q[BYTE_W-1] : 1'b0;
                    end
                end else begin
                    if (ev.scl_rise && cnt_q < CNT_BYTE_DONE) begin
                        rx_q  <= {rx_q[BYTE_W-2:0], ev.sda_lvl};
                        cnt_q <= cnt_q + 1'b1;
                    end
                    if (rx_done) begin
                        if (st_q == ST_DEVADR && !adr_hit) begin
                            st_q <= ST_IDLE;
                        end else begin
                            oe_q     <= 1'b1;
                            ack_ph_q <= 1'b1;
                            if (st_q == ST_DEVADR && rx_q[0]) begin
                                re_q   <= 1'b1;
                                addr_q <= ptr;
                            end
                            if (wr_fire) begin
                                we_q    <= 1'b1;
                                addr_q  <= ptr;
                                wdata_q <= rx_q;
                            end
                        end
                    end
                end
            end
        end
    end

    assign rx_byte   = rx_q;
    assign sda_oe    = oe_q;
    assign reg_addr  = addr_q;
    assign reg_wdata = wdata_q;
    assign reg_we    = we_q;
    assign reg_re    = re_q;

    // R11
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(oe_q) |-> !ev.scl_lvl);

    // R4
    we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        we_q |=> !we_q);

    // R12
    re_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        re_q |=> !re_q);

    // R10
    start_release_chk: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (!oe_q && !we_q));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE) |-> !oe_q);

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
    import i2cr_pkg::*;
#(
    parameter logic [DEVA_W-1:0] DEV_ADDR    = 7'h2A,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [BYTE_W-1:0] reg_rdata
);
    bus_ev_t           ev;
    ptr_cmd_t          pcmd;
    logic [PTR_W-1:0]  ptr;
    logic [BYTE_W-1:0] rx_byte;

    i2cr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2cr_ptr u_ptr (
        .clk    (clk),
        .rst    (rst),
        .cmd    (pcmd),
        .byte_i (rx_byte),
        .ptr_o  (ptr)
    );

    i2cr_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .ptr       (ptr),
        .pcmd      (pcmd),
        .rx_byte   (rx_byte),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_rdata (reg_rdata)
    );

endmodule

// File: tb/sim_i2c_reg_slave.sv
`timescale 1ns/1ps
module sim_i2c_reg_slave;
    localparam int H = 16;
    localparam logic [6:0] MY_ADR = 7'h2A;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_bus;
    logic        sda_oe;
    logic [15:0] reg_addr;
    logic [7:0]  reg_wdata;
    logic        reg_we;
    logic        reg_re;
    logic [7:0]  rdata_q = 8'h00;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [15:0] a;
        logic [7:0]  d;
    } wr_t;
    wr_t wq[$];

    always #4 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    i2c_reg_slave u0 (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (m_scl),
        .sda_i     (sda_bus),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_rdata (rdata_q)
    );

    function automatic logic [7:0] fval(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    // register model: data present only in the cycle after the strobe (R12)
    always @(posedge clk) rdata_q <= reg_re ? fval(reg_addr) : 8'h00;

    // scoreboard monitor for write strobes (R4, R10)
    always @(negedge clk) begin
        if (!rst && reg_we) begin
            checks++;
            if (wq.size() == 0) begin
                fails++;
                $display("FAIL R4/R10 unexpected write got %h@%h expected none",
                         reg_wdata, reg_addr);
            end else begin
                wr_t e;
                e = wq.pop_front();
                if (reg_addr !== e.a || reg_wdata !== e.d) begin
                    fails++;
                    $display("FAIL R4 write got %h@%h expected %h@%h",
                             reg_wdata, reg_addr, e.d, e.a);
                end
            end
        end
    end

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic clk_bit(input bit b, output bit s);
        m_sda = b;
        waitn(H - 2);
        m_scl = 1'b1;
        waitn(H / 2);
        s = sda_bus;
        waitn(H / 2);
        m_scl = 1'b0;
        waitn(2);
    endtask

    task automatic do_start();
        m_sda = 1'b1;
        waitn(H);
        m_scl = 1'b1;
        waitn(H);
        m_sda = 1'b0;
        waitn(H);
        m_scl = 1'b0;
        waitn(2);
    endtask

    task automatic do_stop();
        m_sda = 1'b0;
        waitn(H);
        m_scl = 1'b1;
        waitn(H);
        m_sda = 1'b1;
        waitn(H);
    endtask

    task automatic wr_byte(input logic [7:0] b, input bit exp_ack, input string req);
        bit s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        chk(req, {15'd0, !s}, {15'd0, exp_ack});
    endtask

    task automatic rd_byte(input bit give_ack, input logic [7:0] exp, input string req);
        bit s;
        logic [7:0] v;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            v[i] = s;
        end
        clk_bit(!give_ack, s);
        chk(req, {8'd0, v}, {8'd0, exp});
    endtask

    task automatic part_bits(input logic [7:0] b, input int n);
        bit s;
        for (int i = 0; i < n; i++) clk_bit(b[7-i], s);
    endtask

    task automatic push_wr(input logic [15:0] a, input logic [7:0] d);
        wr_t e;
        e.a = a;
        e.d = d;
        wq.push_back(e);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog (R1..all) got hung run expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        waitn(3);
        // R1: outputs quiet in reset
        chk("R1 oe", {15'd0, sda_oe}, 16'd0);
        chk("R1 strobes", {14'd0, reg_we, reg_re}, 16'd0);
        rst = 1'b0;
        waitn(1);
        chk("R1 after release", {13'd0, sda_oe, reg_we, reg_re}, 16'd0);
        waitn(H);

        // write: pointer 0x1234, three data bytes (R2, R3, R4)
        do_start();
        wr_byte({MY_ADR, 1'b0}, 1'b1, "R2 addr ack");
        wr_byte(8'h12, 1'b1, "R3 ptr hi ack");
        wr_byte(8'h34, 1'b1, "R3 ptr lo ack");
        push_wr(16'h1234, 8'hA0); wr_byte(8'hA0, 1'b1, "R4 data ack");
        push_wr(16'h1235, 8'hA1); wr_byte(8'hA1, 1'b1, "R4 data ack");
        push_wr(16'h1236, 8'hA2); wr_byte(8'hA2, 1'b1, "R4 data ack");
        do_stop();

        // receive-only read keeps pointer across stop (R6), NACK ends (R9)
        do_start();
        wr_byte({MY_ADR, 1'b1}, 1'b1, "R2 read addr ack");
        rd_byte(1'b1, fval(16'h1237), "R6 read first");
        rd_byte(1'b0, fval(16'h1238), "R6 read second");
        rd_byte(1'b0, 8'hFF, "R9 bus released after nack");
        do_stop();
        do_start();
        wr_byte({MY_ADR, 1'b1}, 1'b1, "R2 read addr ack");
        rd_byte(1'b0, fval(16'h1239), "R6 R9 pointer after nack");
        do_stop();

        // pointer-only write then receive read (R5)
        do_start();
        wr_byte({MY_ADR, 1'b0}, 1'b1, "R2 addr ack");
        wr_byte(8'h00, 1'b1, "R3 ptr hi ack");
        wr_byte(8'h40, 1'b1, "R3 ptr lo ack");
        do_stop();
        do_start();
        wr_byte({MY_ADR, 1'b1}, 1'b1, "R2 read addr ack");
        rd_byte(1'b1, fval(16'h0040), "R5 read at set pointer");
        rd_byte(1'b1, fval(16'h0041), "R6 increment");
        rd_byte(1'b0, fval(16'h0042), "R6 increment");
        do_stop();

        // read-byte form with repeated start (R7)
        do_start();
        wr_byte({MY_ADR, 1'b0}, 1'b1, "R2 addr ack");
        wr_byte(8'h5A, 1'b1, "R3 ptr hi ack");
        wr_byte(8'h10, 1'b1, "R3 ptr lo ack");
        do_start();
        wr_byte({MY_ADR, 1'b1}, 1'b1, "R7 read addr ack");
        rd_byte(1'b1, fval(16'h5A10), "R7 first byte");
        rd_byte(1'b0, fval(16'h5A11), "R7 second byte");
        do_stop();

        // wrap (R8)
        do_start();
        wr_byte({MY_ADR, 1'b0}, 1'b1, "R2 addr ack");
        wr_byte(8'hFF, 1'b1, "R3 ptr hi ack");
        wr_byte(8'hFF, 1'b1, "R3 ptr lo ack");
        push_wr(16'hFFFF, 8'h77); wr_byte(8'h77, 1'b1, "R8 data ack");
        push_wr(16'h0000, 8'h88); wr_byte(8'h88, 1'b1, "R8 data ack");
        do_stop();
        do_start();
        wr_byte({MY_ADR, 1'b1}, 1'b1, "R2 read addr ack");
        rd_byte(1'b0, fval(16'h0001), "R8 read after wrap");
        do_stop();

        // address mismatch ignored (R2)
        do_start();
        wr_byte({7'h33, 1'b0}, 1'b0, "R2 mismatch no ack");
        wr_byte(8'h00, 1'b0, "R2 mismatch ignored");
        wr_byte(8'h10, 1'b0, "R2 mismatch ignored");
        wr_byte(8'h99, 1'b0, "R2 mismatch ignored");
        do_stop();
        do_start();
        wr_byte({7'h33, 1'b1}, 1'b0, "R2 mismatch read no ack");
        rd_byte(1'b1, 8'hFF, "R2 mismatch read not driven");
        do_stop();
        do_start();
        wr_byte({MY_ADR, 1'b1}, 1'b1, "R2 read addr ack");
        rd_byte(1'b0, fval(16'h0002), "R2 pointer untouched by mismatch");
        do_stop();

        // aborts mid-byte (R10)
        do_start();
        wr_byte({MY_ADR, 1'b0}, 1'b1, "R2 addr ack");
        wr_byte(8'h01, 1'b1, "R3 ptr hi ack");
        wr_byte(8'h00, 1'b1, "R3 ptr lo ack");
        push_wr(16'h0100, 8'h11); wr_byte(8'h11, 1'b1, "R4 data ack");
        part_bits(8'hC3, 4);
        do_start();
        wr_byte({MY_ADR, 1'b0}, 1'b1, "R10 addr ack after abort");
        wr_byte(8'h02, 1'b1, "R3 ptr hi ack");
        wr_byte(8'h00, 1'b1, "R3 ptr lo ack");
        push_wr(16'h0200, 8'h22); wr_byte(8'h22, 1'b1, "R10 data after abort");
        do_stop();
        do_start();
        wr_byte({MY_ADR, 1'b0}, 1'b1, "R2 addr ack");
        wr_byte(8'h03, 1'b1, "R3 ptr hi ack");
        wr_byte(8'h00, 1'b1, "R3 ptr lo ack");
        part_bits(8'h5C, 3);
        do_stop();
        do_start();
        wr_byte({MY_ADR, 1'b1}, 1'b1, "R2 read addr ack");
        rd_byte(1'b0, fval(16'h0300), "R10 partial byte not written");
        do_stop();

        waitn(H);
        chk("R4 R10 pending writes", 16'(wq.size()), 16'd0);
        done = 1;
        summary();
        $finish;
    end

endmodule